// File: doc/BRIEF.md
# Modem Handshake Register Pair with Diagnostic Loopback

This block is the handshake section of a 16550-style serial port. A control register drives four active-low handshake outputs to a modem. A status register reports four active-low modem inputs. The inputs are resynchronised and watched for edges, and an interrupt request is raised whenever a change has been latched.

The processor side uses single-cycle byte strobes. `reg_sel` chooses the control register (0) or the status register (1). `wr_stb` writes the control register, and `rd_stb` marks a read. A read of the status register clears its change bits.

Bit 4 of the control register selects a diagnostic loopback mode. In that mode:
- the handshake pins are held inactive;
- each control bit appears on one of the status inputs;
- the serial output pin idles high;
- the transmit stream is fed back into the receive path.

The mode is held by a two-state machine. Its states are `MODE_NORMAL` and `MODE_LOOP`. It moves from `MODE_NORMAL` to `MODE_LOOP` (transition ENTER) on a control write with bit 4 set. It returns from `MODE_LOOP` to `MODE_NORMAL` (transition EXIT) on a control write with bit 4 clear. Reset forces `MODE_NORMAL`.

Top module: `uart_modem_ctl`

## Requirements
- R1: Master reset (`rst` high) clears the control register. After reset the control read value is 0x00, all four handshake outputs are high, all change bits are 0 and `msr_irq` is low.
- R2: Control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n`. A bit value of 1 drives its pin low, and 0 drives it high.
- R3: A control read returns the written bits 4..0, with bits 7..5 always 0.
- R4: Status bits 4, 5, 6 and 7 are the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change appears in the status read after two clock edges, through a two-flop synchroniser.
- R5: Status bits 0, 1 and 3 set one edge after the synchronised CTS, DSR or DCD level changes, in either direction.
- R6: Status bit 2 sets only when the synchronised `ri_n` goes from low to high. A high-to-low change of `ri_n` sets no change bit.
- R7: A status read (`rd_stb` with `reg_sel`=1) clears status bits 3..0 at that edge. A control read clears nothing.
- R8: A change detected at the same edge as a status read is kept and shows in the next read. Other change bits are still cleared by that read.
- R9: `msr_irq` is high exactly while any of status bits 3..0 is set.
- R10: In normal mode `ser_out` follows `tx_shift` and `rx_in` follows `ser_in`. In loopback `ser_out` is high, `rx_in` follows `tx_shift`, and `ser_in` is ignored.
- R11: In loopback all four handshake outputs are high and the external modem inputs are ignored. Status CTS, DSR, RI and DCD (bits 4..7) read control bits 1, 0, 2 and 3. Changes of these internal levels set the change bits under the R5 and R6 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Master reset, active high, synchronous |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| wr_stb | input | 1 | Write strobe; writes the control register when `reg_sel`=0 |
| rd_stb | input | 1 | Read strobe; a status read clears the change bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| cts_n | input | 1 | Clear-to-send from the modem, active low |
| dsr_n | input | 1 | Data-set-ready from the modem, active low |
| ri_n | input | 1 | Ring indicator from the modem, active low |
| dcd_n | input | 1 | Carrier detect from the modem, active low |
| dtr_n | output | 1 | Terminal-ready to the modem, active low |
| rts_n | output | 1 | Request-to-send to the modem, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| ser_in | input | 1 | Serial input pin |
| tx_shift | input | 1 | Transmit shifter output |
| ser_out | output | 1 | Serial output pin |
| rx_in | output | 1 | Serial stream to the receiver |
| msr_irq | output | 1 | Modem-status interrupt request |

## Verification
A change bit can be set at the same clock edge as a status read clears the change bits. The test provokes this by changing CTS while an older DSR change is already latched. The status read strobe is timed for the exact edge at which the synchronised CTS edge reaches the detector. The result passes only if the DSR change bit is gone, the CTS change bit survives and the interrupt stays high.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } mdm_mode_e;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned LINE_N   = 4;
    localparam int unsigned LOOP_BIT = 4;
    localparam int unsigned IDX_CTS  = 0;
    localparam int unsigned IDX_DSR  = 1;
    localparam int unsigned IDX_RI   = 2;
    localparam int unsigned IDX_DCD  = 3;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Inactive (high) reset value so reset produces no false edge.
    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '1;
        else     chain_q[0] <= d_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '1;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_mode_fsm.sv
module mdm_mode_fsm
    import uart_mdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctl,
    input  logic      loop_req,
    output mdm_mode_e mode,
    output logic      loop_on
);
    mdm_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_NORMAL;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (wr_ctl && loop_req)  state_d = MODE_LOOP;   // ENTER
            MODE_LOOP:   if (wr_ctl && !loop_req) state_d = MODE_NORMAL; // EXIT
            default:     state_d = MODE_NORMAL;
        endcase
    end

    always_comb begin
        mode    = state_q;
        loop_on = 1'b0;
        unique case (state_q)
            MODE_NORMAL: loop_on = 1'b0;
            MODE_LOOP:   loop_on = 1'b1;
            default:     loop_on = 1'b0;
        endcase
    end

    // R11
    enter_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && loop_req) |=> loop_on);
    // R10
    exit_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !loop_req) |=> !loop_on);
endmodule

// File: rtl/mdm_status.sv
module mdm_status #(
    parameter int unsigned LINE_N = 4,
    parameter int unsigned RI_IDX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_N-1:0] line_n,
    input  logic              clr,
    output logic [LINE_N-1:0] delta,
    output logic [LINE_N-1:0] level
);
    logic [LINE_N-1:0] prev_q;
    logic [LINE_N-1:0] delta_q;
    logic [LINE_N-1:0] edge_hit;

    generate
        for (genvar i = 0; i < LINE_N; i++) begin : g_line
            if (i == RI_IDX) begin : g_trail
                // Only the low-to-high pin transition counts.
                assign edge_hit[i] = ~prev_q[i] & line_n[i];
            end else begin : g_both
                assign edge_hit[i] = prev_q[i] ^ line_n[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '1;
            delta_q <= '0;
        end else begin
            prev_q  <= line_n;
            delta_q <= (clr ? '0 : delta_q) | edge_hit;
        end
    end

    assign delta = delta_q;
    assign level = ~line_n;

    // R8
    keep_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((delta_q & $past(edge_hit)) == $past(edge_hit)));
    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|edge_hit)) |=> (delta_q == '0));
    // R6
    ri_fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!delta_q[RI_IDX] && prev_q[RI_IDX] && !line_n[RI_IDX]) |=> !delta_q[RI_IDX]);
    // R5
    hold_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mdm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             out1_n,
    output logic             out2_n,
    input  logic             ser_in,
    input  logic             tx_shift,
    output logic             ser_out,
    output logic             rx_in,
    output logic             msr_irq
);
    localparam int unsigned PAD_W = REG_W - LOOP_BIT - 1;

    logic [LINE_N-1:0] ctl_q;
    logic              wr_ctl;
    logic              rd_sts;
    logic              loop_on;
    mdm_mode_e         mode;
    logic [LINE_N-1:0] ext_raw_n;
    logic [LINE_N-1:0] ext_sync_n;
    logic [LINE_N-1:0] loop_n;
    logic [LINE_N-1:0] eff_n;
    logic [LINE_N-1:0] delta;
    logic [LINE_N-1:0] level;

    assign wr_ctl = wr_stb && !reg_sel;
    assign rd_sts = rd_stb && reg_sel;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wdata[LINE_N-1:0];
    end

    mdm_mode_fsm u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_ctl   (wr_ctl),
        .loop_req (wdata[LOOP_BIT]),
        .mode     (mode),
        .loop_on  (loop_on)
    );

    assign ext_raw_n[IDX_CTS] = cts_n;
    assign ext_raw_n[IDX_DSR] = dsr_n;
    assign ext_raw_n[IDX_RI]  = ri_n;
    assign ext_raw_n[IDX_DCD] = dcd_n;

    mdm_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (ext_raw_n),
        .d_out (ext_sync_n)
    );

    // Loopback cross-wiring: RTS->CTS, DTR->DSR, OUT1->RI, OUT2->DCD.
    assign loop_n[IDX_CTS] = ~ctl_q[1];
    assign loop_n[IDX_DSR] = ~ctl_q[0];
    assign loop_n[IDX_RI]  = ~ctl_q[2];
    assign loop_n[IDX_DCD] = ~ctl_q[3];
    assign eff_n = (mode == MODE_LOOP) ? loop_n : ext_sync_n;

    mdm_status #(.LINE_N(LINE_N), .RI_IDX(IDX_RI)) u_status (
        .clk    (clk),
        .rst    (rst),
        .line_n (eff_n),
        .clr    (rd_sts),
        .delta  (delta),
        .level  (level)
    );

    assign dtr_n   = loop_on | ~ctl_q[0];
    assign rts_n   = loop_on | ~ctl_q[1];
    assign out1_n  = loop_on | ~ctl_q[2];
    assign out2_n  = loop_on | ~ctl_q[3];
    assign ser_out = loop_on | tx_shift;
    assign rx_in   = loop_on ? tx_shift : ser_in;
    assign msr_irq = |delta;

    assign rdata = reg_sel ? {level, delta} : {{PAD_W{1'b0}}, loop_on, ctl_q};

    // R11
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
        loop_on |-> (dtr_n && rts_n && out1_n && out2_n));
    // R10
    loop_serial_chk: assert property (@(posedge clk) disable iff (rst)
        loop_on |-> (ser_out && (rx_in == tx_shift)));
    // R3
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (rdata[REG_W-1:LOOP_BIT+1] == '0));
    // R1
    reset_pins_chk: assert property (@(posedge clk)
        $past(rst) |-> (dtr_n && rts_n && out1_n && out2_n && !msr_irq));
endmodule

// File: tb/uart_modem_ctl_tb_top.sv
module uart_modem_ctl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_sel, wr_stb, rd_stb;
    logic [7:0] wdata, rdata;
    logic       cts_n, dsr_n, ri_n, dcd_n;
    logic       dtr_n, rts_n, out1_n, out2_n;
    logic       ser_in, tx_shift, ser_out, rx_in, msr_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .ser_in(ser_in), .tx_shift(tx_shift), .ser_out(ser_out), .rx_in(rx_in),
        .msr_irq(msr_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [7:0] pins();
        return {4'b0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        reg_sel = 1'b0; wdata = v; wr_stb = 1'b1;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic peek_sts(output logic [7:0] v);
        reg_sel = 1'b1; #1; v = rdata;
    endtask

    task automatic peek_ctl(output logic [7:0] v);
        reg_sel = 1'b0; #1; v = rdata;
    endtask

    task automatic rd_sts();
        reg_sel = 1'b1; rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1; reg_sel = 0; wr_stb = 0; rd_stb = 0; wdata = 0;
        cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; ser_in = 1; tx_shift = 1;
        ticks(3);
        rst = 1'b0;
        peek_ctl(v); check("R1 ctl after reset", v, 8'h00);
        check("R1 pins after reset", pins(), 8'h0F);
        peek_sts(v); check("R1 status after reset", v, 8'h00);
        check("R1 irq after reset", {7'b0, msr_irq}, 8'h00);
    endtask

    task automatic t_ctl_drive();
        logic [7:0] v;
        wr_ctl(8'h05);
        check("R2 pins for 0x05", pins(), 8'h0A);
        wr_ctl(8'hEA);
        check("R2 pins for 0xEA", pins(), 8'h05);
        peek_ctl(v); check("R3 readback of 0xEA", v, 8'h0A);
        wr_ctl(8'h00);
        check("R2 pins for 0x00", pins(), 8'h0F);
    endtask

    task automatic t_edges();
        logic [7:0] v;
        cts_n = 1'b0;
        tick(); peek_sts(v); check("R4 one edge: not yet visible", v, 8'h00);
        tick(); peek_sts(v); check("R4 level after two edges", v, 8'h10);
        tick(); peek_sts(v); check("R5 dcts on fall", v, 8'h11);
        check("R9 irq with delta", {7'b0, msr_irq}, 8'h01);
        rd_sts(); peek_sts(v); check("R7 read clears", v, 8'h10);
        check("R9 irq after clear", {7'b0, msr_irq}, 8'h00);
        cts_n = 1'b1; ticks(3); peek_sts(v); check("R5 dcts on rise", v, 8'h01);
        rd_sts();
        dsr_n = 1'b0; ticks(3); peek_sts(v); check("R5 ddsr", v, 8'h22);
        dcd_n = 1'b0; ticks(3); peek_sts(v); check("R5 ddcd with dsr", v, 8'hAA);
        rd_sts(); peek_sts(v); check("R7 levels kept", v, 8'hA0);
        dsr_n = 1'b1; dcd_n = 1'b1; ticks(3); peek_sts(v); check("R5 both rise", v, 8'h0A);
        rd_sts(); peek_sts(v); check("R7 cleared", v, 8'h00);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        ri_n = 1'b0; ticks(3); peek_sts(v); check("R6 ring start no delta", v, 8'h40);
        check("R9 irq quiet on ring start", {7'b0, msr_irq}, 8'h00);
        ri_n = 1'b1; ticks(3); peek_sts(v); check("R6 trailing edge", v, 8'h04);
        check("R9 irq on trailing edge", {7'b0, msr_irq}, 8'h01);
        rd_sts(); peek_sts(v); check("R7 ring cleared", v, 8'h00);
    endtask

    task automatic t_ctl_read_keeps();
        logic [7:0] v;
        cts_n = 1'b0; ticks(3);
        reg_sel = 1'b0; rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        peek_sts(v); check("R7 control read does not clear", v, 8'h11);
        rd_sts();
        cts_n = 1'b1; ticks(3); rd_sts();
        peek_sts(v); check("R7 clean", v, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        dsr_n = 1'b0; ticks(3);
        cts_n = 1'b0; ticks(2);
        rd_sts();
        peek_sts(v); check("R8 edge at read kept, older cleared", v, 8'h31);
        check("R8 irq kept", {7'b0, msr_irq}, 8'h01);
        cts_n = 1'b1; dsr_n = 1'b1; ticks(3); rd_sts();
        peek_sts(v); check("R8 clean", v, 8'h00);
    endtask

    task automatic t_loop_serial();
        logic [7:0] v;
        tx_shift = 1'b0; ser_in = 1'b1; #1;
        check("R10 normal paths", {6'b0, ser_out, rx_in}, 8'h01);
        wr_ctl(8'h10);
        peek_ctl(v); check("R3 loop bit readback", v, 8'h10);
        check("R11 pins in loop", pins(), 8'h0F);
        check("R10 loop tx0", {6'b0, ser_out, rx_in}, 8'h02);
        tx_shift = 1'b1; ser_in = 1'b0; #1;
        check("R10 loop tx1 ser_in ignored", {6'b0, ser_out, rx_in}, 8'h03);
        peek_sts(v); check("R11 loop entry no deltas", v, 8'h00);
    endtask

    task automatic t_loop_map();
        logic [7:0] v;
        int line_of [4] = '{1, 0, 2, 3};
        for (int c = 0; c < 4; c++) begin
            logic [7:0] exp_on, exp_off;
            int l = line_of[c];
            exp_on  = 8'(1 << (4 + l)) | ((l == 2) ? 8'h00 : 8'(1 << l));
            exp_off = 8'(1 << l);
            wr_ctl(8'h10 | 8'(1 << c)); tick();
            peek_sts(v); check($sformatf("R11 map ctl%0d on", c), v, exp_on);
            check("R11 pins held", pins(), 8'h0F);
            rd_sts();
            wr_ctl(8'h10); tick();
            peek_sts(v); check($sformatf("R11 map ctl%0d off", c), v, exp_off);
            rd_sts();
        end
        cts_n = 1'b0; dcd_n = 1'b0; ticks(4);
        peek_sts(v); check("R11 external ignored", v, 8'h00);
        cts_n = 1'b1; dcd_n = 1'b1; ticks(3);
        wr_ctl(8'h00); tick();
        peek_sts(v); check("R10 exit clean", v, 8'h00);
        tx_shift = 1'b0; #1;
        check("R10 normal after exit", {6'b0, ser_out, rx_in}, 8'h00);
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        wr_ctl(8'h0F);
        check("R2 all active", pins(), 8'h00);
        cts_n = 1'b0; ticks(3);
        cts_n = 1'b1;
        rst = 1'b1; tick(); rst = 1'b0;
        check("R1 pins after mid reset", pins(), 8'h0F);
        peek_ctl(v); check("R1 ctl after mid reset", v, 8'h00);
        peek_sts(v); check("R1 status after mid reset", v, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ctl_drive();
        t_edges();
        t_ring();
        t_ctl_read_keeps();
        t_same_cycle();
        t_loop_serial();
        t_loop_map();
        t_reset_mid();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule